// File: doc/BRIEF.md
# Timebase Timer with Edge Capture

This peripheral combines two timing functions behind a small byte-wide register bus. The first is a free-running 8-bit up-counter paired with a capture register. Any level change on the capture pin, rising or falling, records the current counter value, but only while the capture flag is clear. The first capture is therefore held until software reads it, and later edges are dropped rather than queued. The pin passes through a two-flop synchronizer before the edge detector.

The second function is a periodic timebase. It raises a flag every 8000 or 16000 clock cycles, which is 1 ms or 2 ms at 8 MHz. Each flag drives an interrupt output through its own enable bit. Both flags are cleared as a side effect of a register read, and writes to them have no effect. If a hardware set and a read-clear of the same flag fall in one cycle, the set is kept.

Top module: `tick_capture_timer`

## Requirements
- R1: After reset, both registers read 0x00 and both interrupt outputs are low.
- R2: The internal 8-bit counter reads 0 at reset and advances by one on every clock edge after reset. Let a new pin level first be sampled at clock edge k, counted from reset release. The capture register then holds (k+1) mod 256, and the capture flag is visible after edge k+2.
- R3: Both a rising and a falling level change on the capture pin start a capture.
- R4: While the capture flag is set, pin edges are discarded and the capture register keeps its value.
- R5: The capture flag is cleared only by a read at address 1. A read at address 0 leaves it set, and a write of 0 to bit 6 leaves it set.
- R6: The timebase flag sets every 8000 clock edges when control bit 5 is 0 and every 16000 when it is 1. The first set occurs at edge 8000 after reset with the default select.
- R7: The timebase flag is cleared by a read at address 0. Writes to bit 3 neither set nor clear it.
- R8: When a flag's hardware set and its read-clear fall on the same clock edge, the flag ends up set.
- R9: cap_irq is high exactly while the capture flag (bit 6) and the capture enable (bit 7) are both 1. tb_irq is high exactly while the timebase flag (bit 3) and the timebase enable (bit 4) are both 1.
- R10: Address 0 holds the control byte: bit 7 capture enable, bit 6 capture flag, bit 5 period select, bit 4 timebase enable, bit 3 timebase flag, bits 2:0 read as 0. Address 1 is the read-only capture register, and writes to it are ignored. Read data is registered: it appears after the clock edge that samples bus_rd and shows the values from before that read's side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 1 | Register select: 0 control/status, 1 capture |
| bus_rd | input | 1 | Read strobe; fires clear-on-read side effects |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cap_pin | input | 1 | Asynchronous capture input |
| cap_irq | output | 1 | Capture interrupt request |
| tb_irq | output | 1 | Timebase interrupt request |

## Verification
A flag can be set by hardware on the same clock edge that a register read clears it. The bench provokes this for both flags. It places a capture-register read on the edge where a synchronized pin change loads the register. It places a control-register read on the edge where the timebase period ends. In each case the registered read data must still show the flag clear, and the interrupt output must be high afterwards. A second read then returns the new capture value or the set timebase flag.

// File: rtl/tct_pkg.sv
package tct_pkg;

  // Control byte, upper five bits; low three bits read as zero.
  typedef struct packed {
    logic cap_ie;    // bit 7
    logic cap_flag;  // bit 6
    logic tb_sel;    // bit 5
    logic tb_ie;     // bit 4
    logic tb_flag;   // bit 3
  } ctrl_view_t;

  function automatic logic [7:0] pack_ctrl(ctrl_view_t v);
    return {v, 3'b000};
  endfunction

  function automatic int unsigned tb_period(logic sel, int unsigned p_short,
                                            int unsigned p_long);
    return sel ? p_long : p_short;
  endfunction

endpackage

// File: rtl/tct_edge_sync.sv
module tct_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic edge_o
);
  // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-1:0], pin_i};
  end

  assign edge_o = chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];
endmodule

// File: rtl/tct_capture.sv
module tct_capture #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_flag_o,
  output logic             cap_evt_o
);
  logic [CNT_W-1:0] free_cnt;

  assign cap_evt_o = edge_i & ~cap_flag_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_cnt   <= '0;
      cap_val_o  <= '0;
      cap_flag_o <= 1'b0;
    end else begin
      free_cnt <= free_cnt + 1'b1;
      if (cap_evt_o) cap_val_o <= free_cnt;
      if (cap_evt_o)  cap_flag_o <= 1'b1;
      else if (clr_i) cap_flag_o <= 1'b0;
    end
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_flag_o |=> $stable(cap_val_o));                           // R4
  AST_CAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt_o |=> cap_flag_o);                                    // R8
  AST_CAP_ONLY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_flag_o) |-> $past(clr_i));                          // R5
endmodule

// File: rtl/tct_timebase.sv
module tct_timebase #(
  parameter int unsigned PER_SHORT = 8000,
  parameter int unsigned PER_LONG  = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic clr_i,
  output logic tick_o,
  output logic flag_o
);
  localparam int TB_W = $clog2(PER_LONG + 1);

  logic [TB_W-1:0] tb_cnt;
  logic [TB_W-1:0] last_val;

  assign last_val = TB_W'(tct_pkg::tb_period(sel_i, PER_SHORT, PER_LONG) - 1);
  assign tick_o   = (tb_cnt >= last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_cnt <= '0;
      flag_o <= 1'b0;
    end else begin
      tb_cnt <= tick_o ? '0 : tb_cnt + 1'b1;
      if (tick_o)     flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  AST_TB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (tb_cnt == '0));                                   // R6
  AST_TB_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> flag_o);                                           // R8
  AST_TB_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !tick_o) |=> !flag_o);                              // R7
endmodule

// File: rtl/tick_capture_timer.sv
module tick_capture_timer #(
  parameter int          DATA_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned PER_SHORT   = 8000,
  parameter int unsigned PER_LONG    = 16000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cap_pin,
  output logic              cap_irq,
  output logic              tb_irq
);
  import tct_pkg::*;

  logic              cap_ie, tb_sel, tb_ie;
  logic              pin_edge, cap_evt, cap_flag;
  logic [DATA_W-1:0] cap_val;
  logic              tb_tick, tb_flag;
  logic              rd_ctrl, rd_cap, wr_ctrl;
  logic              unused_wbits;
  ctrl_view_t        ctrl_now;

  assign rd_ctrl      = bus_rd & ~bus_addr;
  assign rd_cap       = bus_rd &  bus_addr;
  assign wr_ctrl      = bus_wr & ~bus_addr;
  assign unused_wbits = ^{bus_wdata[6], bus_wdata[3:0]};

  tct_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_pin), .edge_o(pin_edge));

  tct_capture #(.CNT_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .edge_i(pin_edge), .clr_i(rd_cap),
    .cap_val_o(cap_val), .cap_flag_o(cap_flag), .cap_evt_o(cap_evt));

  tct_timebase #(.PER_SHORT(PER_SHORT), .PER_LONG(PER_LONG)) u_tb (
    .clk(clk), .rst_n(rst_n), .sel_i(tb_sel), .clr_i(rd_ctrl),
    .tick_o(tb_tick), .flag_o(tb_flag));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_ie <= 1'b0;
      tb_sel <= 1'b0;
      tb_ie  <= 1'b0;
    end else if (wr_ctrl) begin
      cap_ie <= bus_wdata[7];
      tb_sel <= bus_wdata[5];
      tb_ie  <= bus_wdata[4];
    end
  end

  assign ctrl_now = '{cap_ie: cap_ie, cap_flag: cap_flag, tb_sel: tb_sel,
                      tb_ie: tb_ie, tb_flag: tb_flag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= bus_addr ? cap_val : pack_ctrl(ctrl_now);
  end

  assign cap_irq = cap_flag & cap_ie;
  assign tb_irq  = tb_flag & tb_ie;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));                              // R10
  AST_CAP_EVT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> !cap_flag);                                       // R4
  AST_CAP_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_ie |-> !cap_irq);                                        // R9
  AST_TB_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_ie |-> !tb_irq);                                          // R9
endmodule

// File: tb/tb_tick_capture_timer.sv
module tb_tick_capture_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       cap_pin = 1'b0;
  logic       cap_irq, tb_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_capture_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .cap_irq(cap_irq), .tb_irq(tb_irq));

  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];
  logic  pend = 1'b0;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: pops one expected item per read and compares the registered data.
  always @(posedge clk) pend <= bus_rd;
  always @(negedge clk) begin
    item_t it;
    if (pend) begin
      if (sb_q.size() == 0) check("R10 unexpected read data", bus_rdata, 8'hxx);
      else begin
        it = sb_q.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic at(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic rd(logic a, logic [7:0] exp, string tag);
    bus_addr = a; bus_rd = 1'b1;
    sb_q.push_back('{exp: exp, tag: tag});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Per R2: a level driven before edge c+1 is sampled at edge k=c+1 and records k+1.
  function automatic logic [7:0] cap_expect(int c);
    return 8'((c + 2) % 256);
  endfunction

  task automatic irq_chk(string tag, logic act, logic exp);
    check(tag, {7'b0, act}, {7'b0, exp});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] e1, e2, e3, e4, e5, e6;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                                   // cyc = 0 at this point

    at(1);  rd(1'b0, 8'h00, "R1 control reset");
    rd(1'b1, 8'h00, "R1 capture reset");
    irq_chk("R1 cap_irq reset", cap_irq, 1'b0);
    irq_chk("R1 tb_irq reset", tb_irq, 1'b0);
    at(5);  wr(1'b0, 8'h90);

    at(20); cap_pin = 1'b1; e1 = cap_expect(cyc);
    at(25); irq_chk("R2 R9 cap_irq after capture", cap_irq, 1'b1);
    rd(1'b0, 8'hD0, "R10 R5 control view with capture flag");
    irq_chk("R5 flag kept after control read", cap_irq, 1'b1);
    at(30); cap_pin = 1'b0;                         // discarded edge
    at(40); rd(1'b1, e1, "R4 R3 rising capture value held");
    irq_chk("R5 flag cleared by capture read", cap_irq, 1'b0);

    at(50); cap_pin = 1'b1; e2 = cap_expect(cyc);
    at(60); rd(1'b1, e2, "R3 rising capture");
    at(70); cap_pin = 1'b0; e3 = cap_expect(cyc);
    at(80); rd(1'b1, e3, "R3 falling capture");
    at(300); cap_pin = 1'b1; e4 = cap_expect(cyc);
    at(310); rd(1'b1, e4, "R2 counter wrap capture");

    at(400); cap_pin = 1'b0; e5 = cap_expect(cyc);
    at(402); rd(1'b1, e4, "R8 read data before same-edge capture");
    irq_chk("R8 capture set beats read clear", cap_irq, 1'b1);
    at(410); rd(1'b1, e5, "R8 colliding capture value");

    at(420); wr(1'b1, 8'hFF);
    at(425); rd(1'b1, e5, "R10 capture register read-only");
    at(430); wr(1'b0, 8'h48);
    at(432); rd(1'b0, 8'h00, "R5 R7 flag bits not writable");
    at(440); cap_pin = 1'b1; e6 = cap_expect(cyc);
    at(445); irq_chk("R9 cap_irq masked", cap_irq, 1'b0);
    at(450); wr(1'b0, 8'h00);
    at(452); rd(1'b0, 8'h40, "R5 write of 0 keeps capture flag");
    at(460); wr(1'b0, 8'h90);
    at(470); rd(1'b1, e6, "R2 capture value");

    at(7999); irq_chk("R6 no tick before 8000", tb_irq, 1'b0);
    at(8000); irq_chk("R6 tick at 8000", tb_irq, 1'b1);
    at(8002); wr(1'b0, 8'h10);
    at(8004); irq_chk("R7 write does not clear tb flag", tb_irq, 1'b1);
    at(8005); rd(1'b0, 8'h18, "R7 R10 control view with tb flag");
    irq_chk("R7 tb flag cleared by read", tb_irq, 1'b0);

    at(8010); wr(1'b0, 8'h30);
    at(23999); irq_chk("R6 no tick before long period", tb_irq, 1'b0);
    at(24000); irq_chk("R6 long period tick", tb_irq, 1'b1);
    at(24002); rd(1'b0, 8'h38, "R6 control after long tick");
    irq_chk("R7 cleared after long tick", tb_irq, 1'b0);

    at(39999); rd(1'b0, 8'h30, "R8 read data before same-edge tick");
    irq_chk("R8 tick set beats read clear", tb_irq, 1'b1);
    at(40002); rd(1'b0, 8'h38, "R8 tb flag survived");

    at(40010); wr(1'b0, 8'h20);
    at(56000); irq_chk("R9 tb_irq masked", tb_irq, 1'b0);
    at(56002); rd(1'b0, 8'h28, "R9 masked flag still set");

    at(56010);
    check("R10 scoreboard drained", 8'(sb_q.size()), 8'h00);
    finish_run();
  end
endmodule